// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block watches 32 already-synchronized input pins and turns chosen transitions or levels on each pin into interrupt requests. Every pin has its own 4-bit sense code. The code picks rising edge, falling edge, either edge, high level or low level. A detected event sets a raw pending flag for that pin. Each flag stays set until software writes 1 to its bit in the clear register.

A pending flag reaches an interrupt output only when two masks let it through. The first is a per-pin acceptance mask. Software reads and writes it directly, and it also stops detection for the pin. The second is an enable mask. Software sets bits in it through one write-one-to-set address and clears bits through another. The masked word feeds two request lines, one for pins 15..0 and one for pins 31..16. When software changes a pin's sense code, it first drops that pin's acceptance bit, so the change cannot record a false event. Choosing which pending pin to serve first is left to software.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset, the acceptance mask, the enable mask, all pending flags and all sense codes read as 0, and both request outputs are low.
- R2: With sense code 0x8, each 0-to-1 change seen on a pin sets its pending flag once. A pin that stays high does not set the flag again after it is cleared.
- R3: With sense code 0x9, each 1-to-0 change on a pin sets its pending flag.
- R4: With sense code 0xC, any change of level on a pin sets its pending flag.
- R5: Sense code 0xA sets the flag while the pin is high, and 0xB sets it while the pin is low. If the level is still active when a clear is written, the flag reads 1 again in the next cycle.
- R6: The sense code of pin n is held at address 0x40 + 4*(n/8), in bits [4*(n%8)+3 : 4*(n%8)]. These four registers read back what was written.
- R7: Sense codes other than 0x8, 0x9, 0xA, 0xB and 0xC detect nothing.
- R8: Address 0x14 is the acceptance mask and can be read and written. While a pin's acceptance bit is 0, no event is recorded for that pin.
- R9: A write to 0x18 sets the enable bit of every pin whose data bit is 1. A write to 0x1C clears the enable bit of every pin whose data bit is 1. Reading either address returns the enable mask.
- R10: Writing 1 to a bit at 0x28 clears that pin's pending flag. If an event for the same pin arrives in the same cycle, the flag stays set.
- R11: Address 0x20 reads the raw pending flags. Address 0x24 reads the pending flags ANDed with the enable mask and the acceptance mask.
- R12: `irq_lo` is the OR of masked bits 15..0, and `irq_hi` is the OR of masked bits 31..16.
- R13: A pin value present before a clock edge is reflected in the pending flags right after that edge. Register writes take effect at the edge on which `reg_wr` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Synchronized pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_lo | output | 1 | Request for pins 15..0 |
| irq_hi | output | 1 | Request for pins 31..16 |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a new event on the same pin. The other hard case is a pin whose acceptance bit is 0 while its level moves. Both need a register write and a pin change lined up to the exact edge. Directed sequences force each of these at a known edge. After that, a seeded random phase toggles pins every cycle and mixes in writes to every register, including sense codes that detect nothing. A cycle-level bench model is compared against the raw word, the masked word and both request lines after every edge.

// File: rtl/pisc_pkg.sv
package pisc_pkg;

  localparam int FIELD_W        = 4;
  localparam int ADDR_W         = 8;
  localparam logic [7:0] OFS_ACCEPT = 8'h14;
  localparam logic [7:0] OFS_EN_SET = 8'h18;
  localparam logic [7:0] OFS_EN_CLR = 8'h1C;
  localparam logic [7:0] OFS_RAW    = 8'h20;
  localparam logic [7:0] OFS_MASKED = 8'h24;
  localparam logic [7:0] OFS_CLEAR  = 8'h28;
  localparam logic [7:0] OFS_SENSE0 = 8'h40;

  typedef enum logic [3:0] {
    SNS_RISE = 4'h8,
    SNS_FALL = 4'h9,
    SNS_HIGH = 4'hA,
    SNS_LOW  = 4'hB,
    SNS_BOTH = 4'hC
  } sense_e;

  // One pin's detection rule: code, present level, level at the previous edge.
  function automatic logic sense_hit(input logic [3:0] code, input logic cur,
                                     input logic prev);
    logic hit;
    case (code)
      SNS_RISE: hit = cur & ~prev;
      SNS_FALL: hit = ~cur & prev;
      SNS_HIGH: hit = cur;
      SNS_LOW:  hit = ~cur;
      SNS_BOTH: hit = cur ^ prev;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Byte address of the sense register with index r.
  function automatic logic [7:0] sense_ofs(input int r);
    return OFS_SENSE0 + 8'(4 * r);
  endfunction

endpackage

// File: rtl/pisc_detect.sv
module pisc_detect
  import pisc_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPIN-1:0]               pin_in,
  input  logic [NPIN-1:0][FIELD_W-1:0]  sense,
  input  logic [NPIN-1:0]               accept,
  output logic [NPIN-1:0]               evt
);

  logic [NPIN-1:0] pin_q;

  // Edge history always tracks the pin; acceptance gates only the event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_in;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign evt[g] = accept[g] & sense_hit(sense[g], pin_in[g], pin_q[g]);
  end

endmodule

// File: rtl/pisc_pending.sv
module pisc_pending #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] evt,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] pend
);

  // A new event has priority over a clear in the same cycle (R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | evt;
  end

endmodule

// File: rtl/pisc_regs.sv
module pisc_regs
  import pisc_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NPIN-1:0]               wdata,
  input  logic [NPIN-1:0]               raw,
  output logic [NPIN-1:0]               accept,
  output logic [NPIN-1:0]               enable,
  output logic [NPIN-1:0][FIELD_W-1:0]  sense,
  output logic [NPIN-1:0]               clr,
  output logic [NPIN-1:0]               masked,
  output logic [NPIN-1:0]               rdata
);

  localparam int PER_REG = NPIN / FIELD_W;   // fields per register
  localparam int NREG    = NPIN / PER_REG;   // sense registers

  logic wr_acc, wr_set, wr_clr, wr_pend;

  assign wr_acc  = wr && (addr == OFS_ACCEPT);
  assign wr_set  = wr && (addr == OFS_EN_SET);
  assign wr_clr  = wr && (addr == OFS_EN_CLR);
  assign wr_pend = wr && (addr == OFS_CLEAR);

  assign clr    = wr_pend ? wdata : '0;
  assign masked = raw & enable & accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept <= '0;
      enable <= '0;
    end else begin
      if (wr_acc) accept <= wdata;
      if (wr_set) enable <= enable | wdata;
      else if (wr_clr) enable <= enable & ~wdata;
    end
  end

  // R6: pin n lives in register n/PER_REG, field n%PER_REG.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense <= '0;
    end else if (wr) begin
      for (int r = 0; r < NREG; r++) begin
        if (addr == sense_ofs(r)) sense[r*PER_REG +: PER_REG] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_ACCEPT:             rdata = accept;
      OFS_EN_SET, OFS_EN_CLR: rdata = enable;
      OFS_RAW:                rdata = raw;
      OFS_MASKED:             rdata = masked;
      default: begin
        for (int r = 0; r < NREG; r++) begin
          if (addr == sense_ofs(r)) rdata = sense[r*PER_REG +: PER_REG];
        end
      end
    endcase
  end

endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pisc_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPIN-1:0]   reg_wdata,
  output logic [NPIN-1:0]   reg_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);

  localparam int HALF = NPIN / 2;

  // Named internal events, brought out for the bound checker.
  logic [NPIN-1:0]              evt_w;
  logic [NPIN-1:0]              clr_w;
  logic [NPIN-1:0]              pend_w;
  logic [NPIN-1:0]              acc_w;
  logic [NPIN-1:0]              en_w;
  logic [NPIN-1:0]              masked_w;
  logic [NPIN-1:0][FIELD_W-1:0] sense_w;

  pisc_regs #(.NPIN(NPIN)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .raw    (pend_w),
    .accept (acc_w),
    .enable (en_w),
    .sense  (sense_w),
    .clr    (clr_w),
    .masked (masked_w),
    .rdata  (reg_rdata)
  );

  pisc_detect #(.NPIN(NPIN)) detect_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .sense  (sense_w),
    .accept (acc_w),
    .evt    (evt_w)
  );

  pisc_pending #(.NPIN(NPIN)) pend_i (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_w),
    .clr   (clr_w),
    .pend  (pend_w)
  );

  // R12: one request per half of the pins.
  assign irq_lo = |masked_w[HALF-1:0];
  assign irq_hi = |masked_w[NPIN-1:HALF];

endmodule

// File: rtl/pin_irq_sense_chk.sv
module pin_irq_sense_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] evt_vec,
  input logic [NPIN-1:0] clr_vec,
  input logic [NPIN-1:0] pend_vec,
  input logic [NPIN-1:0] acc_vec,
  input logic [NPIN-1:0] en_vec,
  input logic            irq_lo,
  input logic            irq_hi
);

  localparam int HALF = NPIN / 2;

  logic [NPIN-1:0] live;
  assign live = pend_vec & en_vec & acc_vec;

  // R8: a pin that is not accepted never produces an event.
  a_r8_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec & ~acc_vec) == '0);

  // R10: a clear without a competing event empties the flag.
  a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec & ~evt_vec) != '0 |=> (pend_vec & $past(clr_vec & ~evt_vec)) == '0);

  // R10 / R13: every event is latched at the next edge, clear or not.
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec != '0 |=> (pend_vec & $past(evt_vec)) == $past(evt_vec));

  // R1: no flag appears without a detected event.
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_vec & ~$past(pend_vec) & ~$past(evt_vec)) == '0);

  // R12: request lines follow the gated flags of their half.
  a_r12_irq_lo: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo == (live[HALF-1:0] != '0));
  a_r12_irq_hi: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi == (live[NPIN-1:HALF] != '0));

endmodule

bind pin_irq_sense pin_irq_sense_chk #(.NPIN(NPIN)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_vec  (evt_w),
  .clr_vec  (clr_w),
  .pend_vec (pend_w),
  .acc_vec  (acc_w),
  .en_vec   (en_w),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi)
);

// File: tb/pin_irq_sense_tb_top.sv
module pin_irq_sense_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_in;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi;

  always #10 clk = ~clk;   // 50 MHz

  pin_irq_sense dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // Reference model state
  logic [31:0] m_pend, m_en, m_acc, m_prev;
  logic [3:0]  m_sense [32];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic ref_hit(input logic [3:0] c, input logic cur, input logic prev);
    if (c == 4'h8) return cur && !prev;
    if (c == 4'h9) return !cur && prev;
    if (c == 4'hA) return cur;
    if (c == 4'hB) return !cur;
    if (c == 4'hC) return cur != prev;
    return 1'b0;
  endfunction

  function automatic logic [31:0] ref_sense_word(input int r);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) w[4*j +: 4] = m_sense[8*r + j];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  // Advance one edge; the model applies what is driven now.
  task automatic tick();
    logic [31:0] evt, clr;
    evt = '0;
    clr = '0;
    for (int i = 0; i < 32; i++)
      evt[i] = m_acc[i] && ref_hit(m_sense[i], pin_in[i], m_prev[i]);
    if (reg_wr) begin
      case (reg_addr)
        8'h14: m_acc = reg_wdata;
        8'h18: m_en = m_en | reg_wdata;
        8'h1C: m_en = m_en & ~reg_wdata;
        8'h28: clr = reg_wdata;
        8'h40, 8'h44, 8'h48, 8'h4C:
          for (int j = 0; j < 8; j++)
            m_sense[8*((reg_addr - 8'h40) / 4) + j] = reg_wdata[4*j +: 4];
        default: ;
      endcase
    end
    m_pend = (m_pend & ~clr) | evt;
    m_prev = pin_in;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    tick();
  endtask

  task automatic check_all(input string tag);
    logic [31:0] mk;
    mk = m_pend & m_en & m_acc;
    rd(8'h20, m_pend, {tag, " R11 raw"});
    rd(8'h24, mk, {tag, " R11 masked"});
    chk({tag, " R12 irq_lo"}, {31'd0, irq_lo}, {31'd0, |mk[15:0]});
    chk({tag, " R12 irq_hi"}, {31'd0, irq_hi}, {31'd0, |mk[31:16]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    m_pend = '0; m_en = '0; m_acc = '0; m_prev = '0;
    for (int i = 0; i < 32; i++) m_sense[i] = 4'h0;
    rst_n = 1'b0; pin_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h14, 32'h0, "R1 accept");
    rd(8'h18, 32'h0, "R1 enable");
    rd(8'h40, 32'h0, "R1 sense0");
    check_all("R1");

    // R6: sense field placement and readback
    wr(8'h40, 32'h89AB_C012);
    wr(8'h44, 32'hC8B9_A8C9);
    wr(8'h48, 32'h0000_00C0);
    wr(8'h4C, 32'hFEDC_BA98);
    for (int r = 0; r < 4; r++) rd(8'h40 + 8'(4*r), ref_sense_word(r), "R6 readback");
    chk("R6 pin 9 field", {28'd0, m_sense[9]}, 32'hC);
    for (int r = 0; r < 4; r++) wr(8'h40 + 8'(4*r), 32'h8888_8888);

    // R8: not accepted -> no event
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h1C, 32'hFFFF_FFFF, "R9 enable readback");
    pin_in[3] = 1'b1; tick();
    rd(8'h20, 32'h0, "R8 blocked raw");
    pin_in[3] = 1'b0; tick();
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'hFFFF_FFFF, "R8 accept readback");

    // R2 / R13: rising edge, one event, no refire while high
    pin_in[5] = 1'b1; tick();
    rd(8'h20, 32'h0000_0020, "R13 R2 rise latched");
    chk("R12 irq_lo rise", {31'd0, irq_lo}, 32'd1);
    tick();
    wr(8'h28, 32'h0000_0020);
    tick();
    rd(8'h20, 32'h0, "R2 no refire while high");
    check_all("R10");

    // R3: falling edge
    wr(8'h40, 32'h9999_9999);
    pin_in[5] = 1'b0; tick();
    rd(8'h20, 32'h0000_0020, "R3 fall latched");
    wr(8'h28, 32'hFFFF_FFFF);

    // R4: both edges
    wr(8'h44, 32'hCCCC_CCCC);
    pin_in[9] = 1'b1; tick();
    rd(8'h20, 32'h0000_0200, "R4 both rise");
    wr(8'h28, 32'h0000_0200);
    pin_in[9] = 1'b0; tick();
    rd(8'h20, 32'h0000_0200, "R4 both fall");
    wr(8'h28, 32'h0000_0200);

    // R5: level high with persistence, level low
    wr(8'h48, 32'hAAAA_AAAA);
    pin_in[17] = 1'b1; tick();
    rd(8'h20, 32'h0002_0000, "R5 high level");
    chk("R12 irq_hi level", {31'd0, irq_hi}, 32'd1);
    wr(8'h28, 32'h0002_0000);
    rd(8'h20, 32'h0002_0000, "R5 level persists");
    pin_in[17] = 1'b0;
    wr(8'h28, 32'h0002_0000);
    rd(8'h20, 32'h0, "R5 level gone");
    wr(8'h4C, 32'hBBBB_BBBB);
    tick();
    rd(8'h20, 32'hFF00_0000, "R5 low level");
    wr(8'h14, 32'h00FF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    check_all("R8 R10");

    // R9: disable and enable gating
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    tick();
    rd(8'h20, 32'hFF00_0000, "R9 raw kept");
    chk("R9 irq_hi gated", {31'd0, irq_hi}, 32'd0);
    wr(8'h18, 32'h0100_0000);
    check_all("R9");

    // R7: codes that detect nothing
    for (int r = 0; r < 4; r++) wr(8'h40 + 8'(4*r), 32'h0F3D_7E12);
    wr(8'h28, 32'hFFFF_FFFF);
    pin_in = 32'hFFFF_FFFF; tick();
    pin_in = 32'h0; tick();
    rd(8'h20, 32'h0, "R7 invalid codes");

    // R10: clear and event in the same cycle
    wr(8'h40, 32'h8888_8888);
    pin_in[0] = 1'b1;
    wr(8'h28, 32'h0000_0001);
    rd(8'h20, 32'h0000_0001, "R10 event wins");
    pin_in[0] = 1'b0;
    wr(8'h18, 32'hFFFF_FFFF);

    // Random phase
    for (int c = 0; c < 2000; c++) begin
      pin_in = pin_in ^ ($urandom & $urandom & $urandom);
      if ($urandom % 3 == 0) begin
        int k;
        logic [31:0] d;
        k = $urandom % 8;
        d = $urandom;
        if (k >= 4) begin
          for (int j = 0; j < 8; j++) begin
            int s;
            s = $urandom % 8;
            d[4*j +: 4] = (s < 5) ? 4'(8 + s) : ((s == 5) ? 4'h0 : ((s == 6) ? 4'h3 : 4'hD));
          end
          reg_addr = 8'h40 + 8'(4 * (k - 4));
        end else begin
          case (k)
            0: reg_addr = 8'h14;
            1: reg_addr = 8'h18;
            2: reg_addr = 8'h1C;
            default: reg_addr = 8'h28;
          endcase
        end
        reg_wr = 1'b1;
        reg_wdata = d;
      end
      tick();
      check_all("R2 R3 R4 R5 R13 random");
    end
    for (int r = 0; r < 4; r++) rd(8'h40 + 8'(4*r), ref_sense_word(r), "R6 random readback");
    rd(8'h14, m_acc, "R8 random accept");
    rd(8'h18, m_en, "R9 random enable");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule